// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer with an independent write clock and read clock. The storage is an inferred register array of D = 2**ADDR_W words. Both pointers cross between the clock domains as Gray code through two-flop synchronisers. Each domain derives its own status flags from its local pointer and the synchronised pointer of the other domain.

The timing mode is captured while the shared asynchronous reset is held. In standard mode, every word leaves the buffer only on a requested read. In fall-through mode, the oldest word is moved into the output register without a request. That register then counts as one extra word of capacity, so every flag threshold in this mode sits one word later.

All status outputs are active low. The polarity of the two main flags follows the mode. In standard mode, `rd_flag_o` is an empty flag (low = empty) and `wr_flag_o` is a full flag (low = full). In fall-through mode, `rd_flag_o` is an output-ready flag (low = valid data on `rd_data_o`) and `wr_flag_o` is an input-ready flag (low = space free).

Top module: `dual_mode_fifo`

## Requirements
- R1: `mode_i` is sampled only while `rst_ni` is low. 0 selects standard mode and 1 selects fall-through mode. Changing `mode_i` after reset has no effect.
- R2: After reset the FIFO is empty, and the flags read as follows. `almost_empty_no`=0, `half_no`=1 and `almost_full_no`=1. In standard mode `rd_flag_o`=0 and `wr_flag_o`=1. In fall-through mode `rd_flag_o`=1 and `wr_flag_o`=0.
- R3: In standard mode, a read accepted at a read-clock edge puts the oldest word on `rd_data_o` at that edge, and words leave in write order. `rd_flag_o` is 1 while any word is stored and 0 once the last word has been read.
- R4: In standard mode, `wr_flag_o` goes to 0 once D words are stored and returns to 1 after the first read. A write while full is dropped and leaves stored data intact.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `rd_data_o` at the third read-clock edge after the write, with no read request. At that edge `rd_flag_o` goes to 0. Each later word is advanced by a read, and `rd_flag_o` returns to 1 after the last word is consumed.
- R6: In fall-through mode the capacity is D+1 words. `wr_flag_o` goes to 1 after D+1 writes with no reads and returns to 0 after the first read. Further writes while it is 1 are dropped.
- R7: A read request while the FIFO is empty is ignored in both modes. `rd_data_o` and the read position are unchanged.
- R8: With n = `empty_ofs_i`, `almost_empty_no` is 1 when more than n words are stored in standard mode, or more than n+1 words in fall-through mode, and 0 otherwise.
- R9: `half_no` is 0 when at least D/2+1 words are stored in standard mode, or at least D/2+2 words in fall-through mode.
- R10: With m = `full_ofs_i`, `almost_full_no` is 0 when at least D−m words are stored in standard mode, or at least D+1−m words in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| mode_i | input | 1 | Timing mode sampled during reset (0 standard, 1 fall-through) |
| wr_en_i | input | 1 | Write request, write clock domain |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request, read clock domain |
| rd_data_o | output | DATA_W | Output data register |
| empty_ofs_i | input | ADDR_W+1 | Almost-empty offset n |
| full_ofs_i | input | ADDR_W+1 | Almost-full offset m |
| wr_flag_o | output | 1 | Full flag (standard) or input-ready flag (fall-through) |
| rd_flag_o | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |
| half_no | output | 1 | Half-full flag, active low |
| almost_empty_no | output | 1 | Programmable almost-empty flag, active low |
| almost_full_no | output | 1 | Programmable almost-full flag, active low |

## Verification
The bench builds the block with ADDR_W=3 (D=8), DATA_W=8 and both offsets set to 2. With these values, every threshold is reached within a few writes: full, half-full, both almost flags, and the extra word of fall-through capacity. The read clock runs at a period with no common edge with the 100 MHz write clock. This makes the three-edge fall-through latency observable without edge coincidence. The bench checks each flag after every single write and read in both modes, so each threshold is checked from both sides.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dmfifo_sync.sv
module dmfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dmfifo_wr_ctrl.sv
module dmfifo_wr_ctrl
  import dmfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W:0]   full_ofs_i,
  input  logic [ADDR_W:0]   rptr_gray_i,
  output logic              wr_fire_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wptr_gray_o,
  output logic              wr_flag_o,
  output logic              half_no,
  output logic              almost_full_no
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2 + 1);

  fifo_mode_e       mode_q;
  logic [PTR_W-1:0] wptr_bin_q, wptr_gray_q, wptr_nxt, rptr_bin, cnt, cnt_nxt, paf_thr;
  logic             full_q, hf_nq, paf_nq, wr_fire;

  // mode captured while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(mode_i);
  end

  assign rptr_bin = PTR_W'(gray_to_bin(32'(rptr_gray_i)));
  assign wr_fire  = wr_en_i & ~full_q;
  assign wptr_nxt = wptr_bin_q + PTR_W'(wr_fire);
  assign cnt      = wptr_bin_q - rptr_bin;
  assign cnt_nxt  = wptr_nxt - rptr_bin;
  assign paf_thr  = DEPTH_P - full_ofs_i;

  // thresholds apply to array occupancy; in fall-through the output word adds one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_bin_q  <= '0;
      wptr_gray_q <= '0;
      full_q      <= 1'b0;
      hf_nq       <= 1'b1;
      paf_nq      <= 1'b1;
    end else begin
      wptr_bin_q  <= wptr_nxt;
      wptr_gray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      full_q      <= (cnt_nxt == DEPTH_P);
      hf_nq       <= !(cnt_nxt >= HALF_P);
      paf_nq      <= !(cnt_nxt >= paf_thr);
    end
  end

  assign wr_fire_o      = wr_fire;
  assign waddr_o        = wptr_bin_q[ADDR_W-1:0];
  assign wptr_gray_o    = wptr_gray_q;
  assign wr_flag_o      = (mode_q == MODE_FWFT) ? full_q : ~full_q;
  assign half_no        = hf_nq;
  assign almost_full_no = paf_nq;

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |-> (cnt < DEPTH_P));
  a_r4_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_en_i) |=> $stable(wptr_bin_q));
  a_r3_gray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wptr_gray_q ^ $past(wptr_gray_q)) <= 1);
endmodule

// File: rtl/dmfifo_rd_ctrl.sv
module dmfifo_rd_ctrl
  import dmfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W:0]   empty_ofs_i,
  input  logic [ADDR_W:0]   wptr_gray_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rptr_gray_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_flag_o,
  output logic              almost_empty_no
);
  localparam int PTR_W = ADDR_W + 1;

  fifo_mode_e        mode_q;
  logic              fwft;
  logic [PTR_W-1:0]  rptr_bin_q, rptr_gray_q, rptr_nxt, wptr_bin, cnt, cnt_nxt;
  logic              ne_q, pae_nq, ov_q, pop;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(mode_i);
  end

  assign fwft     = (mode_q == MODE_FWFT);
  assign wptr_bin = PTR_W'(gray_to_bin(32'(wptr_gray_i)));
  assign cnt      = wptr_bin - rptr_bin_q;
  // standard: requested read of a non-empty array; fall-through: refill output register
  assign pop      = fwft ? ((cnt != '0) && (!ov_q || rd_en_i)) : (rd_en_i && ne_q);
  assign rptr_nxt = rptr_bin_q + PTR_W'(pop);
  assign cnt_nxt  = wptr_bin - rptr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_bin_q  <= '0;
      rptr_gray_q <= '0;
      ne_q        <= 1'b0;
      pae_nq      <= 1'b0;
      ov_q        <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rptr_bin_q  <= rptr_nxt;
      rptr_gray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      ne_q        <= (cnt_nxt != '0);
      pae_nq      <= (cnt_nxt > empty_ofs_i);
      ov_q        <= fwft & (pop | (ov_q & ~rd_en_i));
      if (pop) rdata_q <= mem_rdata_i;
    end
  end

  assign raddr_o         = rptr_bin_q[ADDR_W-1:0];
  assign rptr_gray_o     = rptr_gray_q;
  assign rd_data_o       = rdata_q;
  assign rd_flag_o       = fwft ? ~ov_q : ne_q;
  assign almost_empty_no = pae_nq;

  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> (cnt != '0));
  a_r7_empty_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && rd_en_i && !ne_q) |=> ($stable(rptr_bin_q) && $stable(rdata_q)));
  a_r5_head_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft && ov_q && !rd_en_i) |=> (ov_q && $stable(rdata_q)));
  a_r3_std_no_valid_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwft |=> !ov_q);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W:0]   empty_ofs_i,
  input  logic [ADDR_W:0]   full_ofs_i,
  output logic              wr_flag_o,
  output logic              rd_flag_o,
  output logic              half_no,
  output logic              almost_empty_no,
  output logic              almost_full_no
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wr_fire;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wptr_gray, rptr_gray, wptr_gray_rs, rptr_gray_ws;

  always_ff @(posedge wclk_i) begin
    if (wr_fire) mem_q[waddr] <= wr_data_i;
  end

  dmfifo_sync #(.W(PTR_W)) u_sync_w2r (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (wptr_gray), .q_o (wptr_gray_rs)
  );

  dmfifo_sync #(.W(PTR_W)) u_sync_r2w (
    .clk_i (wclk_i), .rst_ni (rst_ni), .d_i (rptr_gray), .q_o (rptr_gray_ws)
  );

  dmfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i          (wclk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode_i),
    .wr_en_i        (wr_en_i),
    .full_ofs_i     (full_ofs_i),
    .rptr_gray_i    (rptr_gray_ws),
    .wr_fire_o      (wr_fire),
    .waddr_o        (waddr),
    .wptr_gray_o    (wptr_gray),
    .wr_flag_o      (wr_flag_o),
    .half_no        (half_no),
    .almost_full_no (almost_full_no)
  );

  dmfifo_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i           (rclk_i),
    .rst_ni          (rst_ni),
    .mode_i          (mode_i),
    .rd_en_i         (rd_en_i),
    .empty_ofs_i     (empty_ofs_i),
    .wptr_gray_i     (wptr_gray_rs),
    .mem_rdata_i     (mem_q[raddr]),
    .raddr_o         (raddr),
    .rptr_gray_o     (rptr_gray),
    .rd_data_o       (rd_data_o),
    .rd_flag_o       (rd_flag_o),
    .almost_empty_no (almost_empty_no)
  );
endmodule

// File: tb/dual_mode_fifo_tb.sv
`timescale 1ns/100ps
module dual_mode_fifo_tb;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int D  = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW:0]   e_ofs = 4'd2, f_ofs = 4'd2;
  logic          wr_flag, rd_flag, hf_n, pae_n, paf_n;

  logic [DW-1:0] exp_q[$];
  int checks = 0, errors = 0;

  always #5   wclk = ~wclk;
  always #7.3 rclk = ~rclk;

  dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_n), .mode_i (mode),
    .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_en_i (rd_en), .rd_data_o (rd_data),
    .empty_ofs_i (e_ofs), .full_ofs_i (f_ofs),
    .wr_flag_o (wr_flag), .rd_flag_o (rd_flag), .half_no (hf_n),
    .almost_empty_no (pae_n), .almost_full_no (paf_n)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    rst_n <= 1'b0; mode <= m; wr_en <= 1'b0; rd_en <= 1'b0;
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    @(negedge wclk) rst_n <= 1'b1;
    exp_q.delete();
    settle();
  endtask

  // driver: scoreboard entry added only when the model has room
  task automatic push(input logic [DW-1:0] d, input bit keep);
    @(negedge wclk);
    wr_en <= 1'b1; wr_data <= d;
    @(posedge wclk);
    wr_en <= 1'b0;
    if (keep) exp_q.push_back(d);
  endtask

  task automatic pop_std();
    logic [DW-1:0] e;
    @(negedge rclk) rd_en <= 1'b1;
    @(posedge rclk) rd_en <= 1'b0;
    #1;
    e = exp_q.pop_front();
    chk(rd_data == e, "R3", "read data", int'(rd_data), int'(e));
  endtask

  task automatic pop_fwft();
    @(negedge rclk);
    chk(rd_flag == 1'b0, "R5", "output ready before read", int'(rd_flag), 0);
    chk(rd_data == exp_q[0], "R5", "head word", int'(rd_data), int'(exp_q[0]));
    rd_en <= 1'b1;
    @(posedge rclk) rd_en <= 1'b0;
    void'(exp_q.pop_front());
    #1;
  endtask

  task automatic flags_std();
    int c = exp_q.size();
    chk(rd_flag == (c != 0), "R3", "empty flag", int'(rd_flag), int'(c != 0));
    chk(wr_flag == (c != D), "R4", "full flag", int'(wr_flag), int'(c != D));
    chk(pae_n == (c > 2), "R8", "almost-empty", int'(pae_n), int'(c > 2));
    chk(hf_n == !(c >= D/2 + 1), "R9", "half-full", int'(hf_n), int'(!(c >= D/2 + 1)));
    chk(paf_n == !(c >= D - 2), "R10", "almost-full", int'(paf_n), int'(!(c >= D - 2)));
  endtask

  task automatic flags_fwft();
    int t = exp_q.size();
    chk(rd_flag == (t == 0), "R5", "output-ready", int'(rd_flag), int'(t == 0));
    chk(wr_flag == (t == D + 1), "R6", "input-ready", int'(wr_flag), int'(t == D + 1));
    chk(pae_n == (t > 3), "R8", "almost-empty", int'(pae_n), int'(t > 3));
    chk(hf_n == !(t >= D/2 + 2), "R9", "half-full", int'(hf_n), int'(!(t >= D/2 + 2)));
    chk(paf_n == !(t >= D - 1), "R10", "almost-full", int'(paf_n), int'(!(t >= D - 1)));
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] last;
    // standard mode
    do_reset(1'b0);
    chk(rd_flag == 1'b0 && wr_flag == 1'b1, "R2", "std reset main flags", {rd_flag, wr_flag}, 1);
    chk(pae_n == 1'b0 && hf_n == 1'b1 && paf_n == 1'b1, "R2", "std reset aux flags", {pae_n, hf_n, paf_n}, 3);
    mode <= 1'b1;  // ignored after reset
    for (int i = 0; i < D; i++) begin
      push(DW'(8'h10 + i), 1'b1);
      settle();
      if (i == 0) chk(rd_flag == 1'b1, "R1", "still standard after mode change", int'(rd_flag), 1);
      flags_std();
    end
    push(8'hEE, 1'b0);  // R4: dropped while full
    settle();
    flags_std();
    for (int i = 0; i < D; i++) begin
      pop_std();
      settle();
      flags_std();
    end
    last = rd_data;
    @(negedge rclk) rd_en <= 1'b1;
    @(posedge rclk) rd_en <= 1'b0;
    settle();
    chk(rd_data == last, "R7", "std empty read keeps data", int'(rd_data), int'(last));
    chk(rd_flag == 1'b0, "R7", "std still empty", int'(rd_flag), 0);
    push(8'h5A, 1'b1);
    settle();
    pop_std();  // R7: read position not moved by the ignored request

    // fall-through mode
    do_reset(1'b1);
    chk(rd_flag == 1'b1 && wr_flag == 1'b0, "R2", "fwft reset main flags", {rd_flag, wr_flag}, 2);
    chk(pae_n == 1'b0 && hf_n == 1'b1 && paf_n == 1'b1, "R2", "fwft reset aux flags", {pae_n, hf_n, paf_n}, 3);
    mode <= 1'b0;  // R1: ignored after reset
    push(8'hA0, 1'b1);
    repeat (2) @(posedge rclk);
    #1;
    chk(rd_flag == 1'b1, "R5", "not ready after two read edges", int'(rd_flag), 1);
    @(posedge rclk);
    #1;
    chk(rd_flag == 1'b0, "R5", "ready at third read edge", int'(rd_flag), 0);
    chk(rd_data == 8'hA0, "R5", "first word falls through", int'(rd_data), 8'hA0);
    settle();
    chk(rd_flag == 1'b0, "R1", "still fall-through after mode change", int'(rd_flag), 0);
    flags_fwft();
    for (int i = 1; i <= D; i++) begin
      push(DW'(8'hA0 + i), 1'b1);
      settle();
      flags_fwft();
    end
    push(8'hEE, 1'b0);  // R6: dropped at D+1 words
    settle();
    flags_fwft();
    pop_fwft();
    settle();
    chk(wr_flag == 1'b0, "R6", "first read from full frees space", int'(wr_flag), 0);
    flags_fwft();
    while (exp_q.size() > 0) begin
      pop_fwft();
      settle();
      flags_fwft();
    end
    last = rd_data;
    @(negedge rclk) rd_en <= 1'b1;
    @(posedge rclk) rd_en <= 1'b0;
    settle();
    chk(rd_data == last, "R7", "fwft empty read keeps data", int'(rd_data), int'(last));
    chk(rd_flag == 1'b1, "R7", "fwft still not ready", int'(rd_flag), 1);
    push(8'hB7, 1'b1);
    settle();
    pop_fwft();
    settle();
    flags_fwft();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule